// File: doc/BRIEF.md
# Serial Character Receiver with Parity and Framing Checks

This block recovers characters from an asynchronous serial line. It receives a strobe at sixteen times the bit rate. It runs the line through a two-flop synchronizer and then hunts for a falling edge. It confirms the start bit halfway through the bit, and then samples each data bit, the optional parity bit and the stop bit near its middle. The least significant data bit arrives first.

The line settings match those of a companion transmitter: a word length of 5 to 8 bits and a parity choice of none, odd, even or stick. The block latches the settings when a start bit is detected, so a change partway through a character does not affect that character. Each character is delivered as a byte with a one-clock valid strobe. The parity-error and framing-error flags are raised in the same cycle as the strobe.

Top module: `serial_char_rx`

## Requirements
- R1: After a synchronous reset, `rx_valid`, `rx_perr`, `rx_ferr` and `rx_data` are all zero.
- R2: `cfg_wlen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits are received least significant first, and the bits of `rx_data` above the word length read zero.
- R3: With `cfg_par_en`=0, no parity bit is expected. The bit after the last data bit is the stop bit, and `rx_perr` stays 0.
- R4: With `cfg_par_en`=1 and `cfg_par_stick`=0, `cfg_par_even`=1 selects even parity and 0 selects odd parity. Even parity means the data bits plus the parity bit hold an even count of ones; odd parity means an odd count. A mismatch raises `rx_perr`.
- R5: With `cfg_par_en`=1 and `cfg_par_stick`=1, the expected parity bit is the inverse of `cfg_par_even`, whatever the data. A received bit that differs raises `rx_perr`.
- R6: A stop bit sampled low raises `rx_ferr`. A high stop bit leaves it at 0. Only the first stop bit is checked.
- R7: A low pulse that has gone high again 8 ticks after it was detected is discarded as a glitch and produces no character.
- R8: A start is only recognised after the line has been seen high at a tick while hunting. A line held low from reset produces no character.
- R9: Each character produces exactly one `rx_valid` pulse, one clock long. `rx_data`, `rx_perr` and `rx_ferr` are valid in that cycle, and the two flags are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock strobe at 16x the bit rate |
| cfg_wlen | input | 2 | Word length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select; in stick mode, the inverse of the expected bit |
| cfg_par_stick | input | 1 | Stick parity mode |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-clock character strobe |
| rx_perr | output | 1 | Parity error for the character |
| rx_ferr | output | 1 | Framing error for the character |

## Verification
The bench sweeps all four word lengths against all five parity settings: none, odd, even and the two stick values. It uses all-zero, all-one and mixed data patterns. The all-zero and all-one patterns expose a wrong bit count or a parity polarity swap, and the mixed patterns expose bit-order and masking faults. The bench then sends characters with the parity bit inverted, which separates a real parity check from a flag that never fires, and characters with a low stop bit, which do the same for the framing check. A short low glitch and a line held low from reset show that only a confirmed start edge opens a character.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DW   = 8;
  localparam int SRX_MINW = 5;
  localparam int SRX_WLW  = $clog2(SRX_DW - SRX_MINW + 1);

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } srx_state_e;

  typedef struct packed {
    logic [SRX_WLW-1:0] wlen;
    logic               par_en;
    logic               par_even;
    logic               par_stick;
  } srx_cfg_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/srx_parity.sv
module srx_parity
  import srx_pkg::*;
#(
  parameter int DW = SRX_DW
) (
  input  logic [DW-1:0] data,
  input  logic          par_bit,
  input  srx_cfg_t      cfg,
  output logic          perr
);
  logic ones_odd;

  always_comb begin
    ones_odd = ^data;
    if (!cfg.par_en)         perr = 1'b0;
    else if (cfg.par_stick)  perr = (par_bit != ~cfg.par_even);
    else if (cfg.par_even)   perr = (ones_odd ^ par_bit);
    else                     perr = ~(ones_odd ^ par_bit);
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int DW   = SRX_DW,
  parameter int MINW = SRX_MINW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd_s,
  input  srx_cfg_t      cfg_i,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          par_bit,
  output logic          stop_bit,
  output srx_cfg_t      cfg_q
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OVS / 2;

  srx_state_e    state;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic          line_hi;
  logic [BW-1:0] last_idx;
  logic          half_hit;
  logic          full_hit;

  assign last_idx = BW'(MINW - 1) + BW'(cfg_q.wlen);
  assign half_hit = (tcnt == CW'(HALF - 1));
  assign full_hit = (tcnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      tcnt     <= '0;
      bidx     <= '0;
      line_hi  <= 1'b0;
      word     <= '0;
      par_bit  <= 1'b0;
      stop_bit <= 1'b1;
      done     <= 1'b0;
      cfg_q    <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_HUNT: begin
            if (rxd_s) begin
              line_hi <= 1'b1;
            end else if (line_hi) begin
              state <= ST_START;
              tcnt  <= '0;
              bidx  <= '0;
              word  <= '0;
              cfg_q <= cfg_i;
            end
          end
          ST_START: begin
            if (half_hit) begin
              tcnt <= '0;
              if (rxd_s) begin
                state   <= ST_HUNT;
                line_hi <= 1'b1;
              end else begin
                state <= ST_DATA;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (full_hit) begin
              tcnt       <= '0;
              word[bidx] <= rxd_s;
              if (bidx == last_idx) begin
                bidx  <= '0;
                state <= cfg_q.par_en ? ST_PAR : ST_STOP;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (full_hit) begin
              tcnt    <= '0;
              par_bit <= rxd_s;
              state   <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (full_hit) begin
              tcnt     <= '0;
              stop_bit <= rxd_s;
              done     <= 1'b1;
              line_hi  <= rxd_s;
              state    <= ST_HUNT;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import srx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DW        = SRX_DW,
  parameter int MINW      = SRX_MINW,
  parameter int SYNC_LEN  = 2,
  localparam int WLW      = SRX_WLW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [WLW-1:0] cfg_wlen,
  input  logic           cfg_par_en,
  input  logic           cfg_par_even,
  input  logic           cfg_par_stick,
  input  logic           rxd,
  output logic [DW-1:0]  rx_data,
  output logic           rx_valid,
  output logic           rx_perr,
  output logic           rx_ferr
);
  logic          rxd_s;
  logic          done;
  logic [DW-1:0] word;
  logic          par_bit;
  logic          stop_bit;
  logic          perr_c;
  srx_cfg_t      cfg_in;
  srx_cfg_t      cfg_q;
  logic [WLW-1:0] lat_wlen;
  logic           lat_par_en;

  assign cfg_in     = '{wlen: cfg_wlen, par_en: cfg_par_en,
                        par_even: cfg_par_even, par_stick: cfg_par_stick};
  assign lat_wlen   = cfg_q.wlen;
  assign lat_par_en = cfg_q.par_en;

  srx_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  srx_ctrl #(.OVS(OVS), .DW(DW), .MINW(MINW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .rxd_s   (rxd_s),
    .cfg_i   (cfg_in),
    .done    (done),
    .word    (word),
    .par_bit (par_bit),
    .stop_bit(stop_bit),
    .cfg_q   (cfg_q)
  );

  srx_parity #(.DW(DW)) u_par (
    .data   (word),
    .par_bit(par_bit),
    .cfg    (cfg_q),
    .perr   (perr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= done;
      rx_perr  <= done & perr_c;
      rx_ferr  <= done & ~stop_bit;
      if (done) rx_data <= word;
    end
  end
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk #(
  parameter int DW   = 8,
  parameter int MINW = 5,
  parameter int WLW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [DW-1:0]  rx_data,
  input logic           rx_valid,
  input logic           rx_perr,
  input logic           rx_ferr,
  input logic [WLW-1:0] lat_wlen,
  input logic           lat_par_en
);
  localparam int WLMAX = DW - MINW;

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9
  flags_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_perr || rx_ferr) |-> rx_valid);

  // R3
  no_parity_no_perr_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !lat_par_en) |-> !rx_perr);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data & ~({DW{1'b1}} >> (WLMAX - int'(lat_wlen)))) == '0));
endmodule

bind serial_char_rx serial_char_rx_chk #(.DW(DW), .MINW(MINW), .WLW(WLW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .rx_perr   (rx_perr),
  .rx_ferr   (rx_ferr),
  .lat_wlen  (lat_wlen),
  .lat_par_en(lat_par_en)
);

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;
  localparam int CLK_NS  = 10;
  localparam int TDIV    = 4;
  localparam int BITCLK  = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       rxd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_perr;
  logic       rx_ferr;

  int checks = 0;
  int failures = 0;
  int vcnt = 0;
  logic [7:0] cap_data;
  logic cap_perr, cap_ferr;
  int div = 0;
  bit finished = 0;

  serial_char_rx u0 (
    .clk(clk), .rst(rst), .tick(tick), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    div  <= (div == TDIV-1) ? 0 : div + 1;
    tick <= (div == TDIV-1);
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt     <= vcnt + 1;
      cap_data <= rx_data;
      cap_perr <= rx_perr;
      cap_ferr <= rx_ferr;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  // pm: 0 none, 1 odd, 2 even, 3 stick expecting 1, 4 stick expecting 0
  task automatic send_char(input logic [7:0] d, input int wl, input int pm,
                           input bit flip_par, input logic stop_v);
    int nb;
    logic [7:0] m;
    logic pb;
    bit pen, pev, pst;
    nb  = 5 + wl;
    m   = 8'hFF >> (3 - wl);
    pen = (pm != 0);
    pev = (pm == 2) || (pm == 4);
    pst = (pm >= 3);
    cfg_wlen = 2'(wl); cfg_par_en = pen; cfg_par_even = pev; cfg_par_stick = pst;
    if (pst)      pb = ~pev;
    else if (pev) pb = ^(d & m);
    else          pb = ~^(d & m);
    pb = pb ^ flip_par;
    vcnt = 0;
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pen) drive_bit(pb);
    drive_bit(stop_v);
    drive_bit(1'b1);
    drive_bit(1'b1);
    chk(vcnt == 1, $sformatf("R9 one strobe wl=%0d pm=%0d", wl, pm), vcnt, 1);
    chk(cap_data == (d & m), $sformatf("R2 data wl=%0d pm=%0d", wl, pm), cap_data, d & m);
    if (pm == 0)
      chk(cap_perr == 1'b0, "R3 no parity", cap_perr, 0);
    else if (pm <= 2)
      chk(cap_perr == flip_par, $sformatf("R4 parity pm=%0d", pm), cap_perr, flip_par);
    else
      chk(cap_perr == flip_par, $sformatf("R5 stick pm=%0d", pm), cap_perr, flip_par);
    chk(cap_ferr == ~stop_v, "R6 framing", cap_ferr, ~stop_v);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_valid == 0 && rx_perr == 0 && rx_ferr == 0 && rx_data == 0,
        "R1 reset outputs", {rx_valid, rx_perr, rx_ferr, rx_data}, 0);
    vcnt = 0;
    repeat (5 * BITCLK) @(negedge clk);
    chk(vcnt == 0, "R8 low line from reset", vcnt, 0);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);

    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 5; pm++) begin
        send_char(8'h00, wl, pm, 0, 1'b1);
        send_char(8'hFF, wl, pm, 0, 1'b1);
        send_char(8'h5A ^ 8'(wl * 37 + pm * 11), wl, pm, 0, 1'b1);
      end

    for (int pm = 1; pm < 5; pm++) begin
      send_char(8'hC3, 3, pm, 1, 1'b1);
      send_char(8'h16, 0, pm, 1, 1'b1);
    end

    send_char(8'h81, 3, 0, 0, 1'b0);
    send_char(8'h0D, 1, 2, 0, 1'b0);
    send_char(8'h3E, 2, 3, 1, 1'b0);

    vcnt = 0;
    rxd = 1'b0;
    repeat (5 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (15 * BITCLK) @(negedge clk);
    chk(vcnt == 0, "R7 glitch discarded", vcnt, 0);
    send_char(8'h96, 3, 2, 0, 1'b1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule